// File: doc/BRIEF.md
# Three-State Register Status Table

This block sits in the issue stage of an out-of-order scheduler that retires results through a reorder buffer. For every architectural register it holds a status and the reorder buffer tag of the newest instruction that will write that register. The status is one of three values. Available means no write is outstanding. In-flight means the writer has not yet produced its result. Ready means the result exists in the reorder buffer but has not been committed.

Each cycle, the issuing instruction presents two source register indices. The table answers combinationally, for each source, where the operand comes from: the register file, a tag to wait on, or a reorder buffer entry to read. On the following clock edge the table records the issuing instruction as the new writer of its destination. Result-bus broadcasts move matching registers to Ready. Commits move matching registers back to Available. A flush returns every register to Available. The register file and the reorder buffer storage are outside this block.

Top module: `rstat_table`

## Requirements
- R1: After synchronous reset every register is Available, so every source lookup returns kind FILE with tag 0.
- R2: A source whose register is Available returns kind FILE (2'b00) and tag 0.
- R3: A source whose register is In-flight returns kind WAIT (2'b01) and the stored writer tag.
- R4: A source whose register is Ready returns kind ROB (2'b10) and the stored writer tag.
- R5: When `iss_valid` and `iss_dst_en` are both high, the register `iss_dst` becomes In-flight with tag `iss_tag` on the next edge, replacing any earlier writer. If either signal is low, no register changes.
- R6: A broadcast moves a register from In-flight to Ready only when the stored tag equals `bc_tag`. A broadcast with any other tag leaves the register unchanged.
- R7: A commit of register `cm_reg` with tag `cm_tag` makes that register Available when its stored tag equals `cm_tag`.
- R8: A commit whose tag differs from the stored tag leaves the register's state and tag unchanged.
- R9: An In-flight source whose tag is broadcast in the same cycle as the lookup returns kind ROB with that tag.
- R10: The sources are looked up against the state that existed before the same instruction's destination update, including when the destination equals a source.
- R11: `flush` makes every register Available on the next edge, and it overrides a same-cycle issue.
- R12: An issue to a register takes priority over a same-cycle broadcast or commit aimed at that register's previous writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Return all registers to Available |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_en | input | 1 | The issuing instruction writes a destination |
| iss_dst | input | REG_W | Destination register index |
| iss_tag | input | TAG_W | Reorder buffer entry of the issuing instruction |
| iss_src | input | NUM_SRC*REG_W | Source register indices, one field per source |
| src_kind | output | NUM_SRC*2 | Per-source operand origin: 0 FILE, 1 WAIT, 2 ROB |
| src_tag | output | NUM_SRC*TAG_W | Per-source writer tag (0 for FILE) |
| bc_valid | input | 1 | A result is broadcast this cycle |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| cm_valid | input | 1 | A reorder buffer entry commits this cycle |
| cm_reg | input | REG_W | Destination register of the committing entry |
| cm_tag | input | TAG_W | Tag of the committing entry |

## Verification
The bench targets stale tags. It sends a late broadcast and a late commit of an overwritten writer. A table that ignored the tag comparison would promote the register to Ready or free it while a newer writer is still pending. It also looks up a source whose tag is broadcast in the same cycle: a design without the bypass would send that operand to wait on a tag that never comes again. Further cases cover an instruction that reads its own destination, an issue that collides with a broadcast or commit on the same register, and a flush issued together with an issue. A wrong priority in any of these shows up as the wrong kind or tag at the source ports.

// File: rtl/rstat_pkg.sv
package rstat_pkg;

    typedef enum logic [1:0] {
        ST_AVAIL = 2'd0,
        ST_INFL  = 2'd1,
        ST_READY = 2'd2
    } reg_state_e;

    typedef enum logic [1:0] {
        SRC_FILE = 2'd0,
        SRC_WAIT = 2'd1,
        SRC_ROB  = 2'd2
    } src_kind_e;

    // Map a register status onto the operand origin it implies.
    function automatic src_kind_e kind_of(input reg_state_e st);
        src_kind_e k;
        case (st)
            ST_INFL:  k = SRC_WAIT;
            ST_READY: k = SRC_ROB;
            default:  k = SRC_FILE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/rstat_entry.sv
module rstat_entry
    import rstat_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             set_en,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic             cm_hit,
    input  logic [TAG_W-1:0] cm_tag,
    output reg_state_e       state,
    output logic [TAG_W-1:0] tag
);

    reg_state_e       state_d;
    logic [TAG_W-1:0] tag_d;

    always_comb begin
        state_d = state;
        tag_d   = tag;
        if (set_en) begin
            state_d = ST_INFL;
            tag_d   = set_tag;
        end else if (state == ST_INFL && bc_valid && bc_tag == tag) begin
            state_d = ST_READY;
        end else if (state == ST_READY && cm_hit && cm_tag == tag) begin
            state_d = ST_AVAIL;
            tag_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state <= ST_AVAIL;
            tag   <= '0;
        end else begin
            state <= state_d;
            tag   <= tag_d;
        end
    end

    // R5
    issue_sets_inflight_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !flush) |=> (state == ST_INFL && tag == $past(set_tag)));

    // R6
    bcast_match_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && !set_en && state == ST_INFL && bc_valid && bc_tag == tag)
        |=> (state == ST_READY));

    // R8
    commit_mismatch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && !set_en && state == ST_READY && cm_hit && cm_tag != tag)
        |=> (state == ST_READY && $stable(tag)));

    // R11
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (state == ST_AVAIL));

endmodule

// File: rtl/rstat_lookup.sv
module rstat_lookup
    import rstat_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 5,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] sel,
    input  reg_state_e       st_vec  [NUM_REGS],
    input  logic [TAG_W-1:0] tag_vec [NUM_REGS],
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    output logic [1:0]       kind,
    output logic [TAG_W-1:0] tag
);

    reg_state_e       st;
    logic [TAG_W-1:0] tg;
    src_kind_e        k;

    always_comb begin
        st = st_vec[sel];
        tg = tag_vec[sel];
        if (st == ST_INFL && bc_valid && bc_tag == tg) begin
            k = SRC_ROB;
        end else begin
            k = kind_of(st);
        end
        kind = k;
        tag  = (k == SRC_FILE) ? '0 : tg;
    end

    // R2 R3 R4: only the three defined origin codes appear
    kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
        kind != 2'd3);

endmodule

// File: rtl/rstat_table.sv
module rstat_table
    import rstat_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int ROB_DEPTH = 32,
    parameter int NUM_SRC   = 2,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic                           iss_valid,
    input  logic                           iss_dst_en,
    input  logic [REG_W-1:0]               iss_dst,
    input  logic [TAG_W-1:0]               iss_tag,
    input  logic [NUM_SRC-1:0][REG_W-1:0]  iss_src,
    output logic [NUM_SRC-1:0][1:0]        src_kind,
    output logic [NUM_SRC-1:0][TAG_W-1:0]  src_tag,
    input  logic                           bc_valid,
    input  logic [TAG_W-1:0]               bc_tag,
    input  logic                           cm_valid,
    input  logic [REG_W-1:0]               cm_reg,
    input  logic [TAG_W-1:0]               cm_tag
);

    reg_state_e       st_vec  [NUM_REGS];
    logic [TAG_W-1:0] tag_vec [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic set_en;
        logic cm_hit;
        assign set_en = iss_valid && iss_dst_en && (iss_dst == REG_W'(r));
        assign cm_hit = cm_valid && (cm_reg == REG_W'(r));

        rstat_entry #(.TAG_W(TAG_W)) u_entry (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .set_en   (set_en),
            .set_tag  (iss_tag),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .cm_hit   (cm_hit),
            .cm_tag   (cm_tag),
            .state    (st_vec[r]),
            .tag      (tag_vec[r])
        );
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rstat_lookup #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_look (
            .clk      (clk),
            .rst      (rst),
            .sel      (iss_src[s]),
            .st_vec   (st_vec),
            .tag_vec  (tag_vec),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .kind     (src_kind[s]),
            .tag      (src_tag[s])
        );
    end

    // R3: a read of the register written one cycle earlier waits on that writer
    raw_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_dst_en && !flush)
        |=> (!(iss_src[0] == $past(iss_dst) && !(bc_valid && bc_tag == $past(iss_tag)))
             || (src_kind[0] == 2'd1 && src_tag[0] == $past(iss_tag))));

endmodule

// File: tb/sim_rstat_table.sv
module sim_rstat_table;

    localparam int NUM_REGS  = 32;
    localparam int ROB_DEPTH = 32;
    localparam int NUM_SRC   = 2;
    localparam int REG_W     = $clog2(NUM_REGS);
    localparam int TAG_W     = $clog2(ROB_DEPTH);

    localparam int K_FILE = 0;
    localparam int K_WAIT = 1;
    localparam int K_ROB  = 2;

    logic                          clk = 1'b0;
    logic                          rst;
    logic                          flush;
    logic                          iss_valid;
    logic                          iss_dst_en;
    logic [REG_W-1:0]              iss_dst;
    logic [TAG_W-1:0]              iss_tag;
    logic [NUM_SRC-1:0][REG_W-1:0] iss_src;
    logic [NUM_SRC-1:0][1:0]       src_kind;
    logic [NUM_SRC-1:0][TAG_W-1:0] src_tag;
    logic                          bc_valid;
    logic [TAG_W-1:0]              bc_tag;
    logic                          cm_valid;
    logic [REG_W-1:0]              cm_reg;
    logic [TAG_W-1:0]              cm_tag;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rstat_table #(.NUM_REGS(NUM_REGS), .ROB_DEPTH(ROB_DEPTH), .NUM_SRC(NUM_SRC)) u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .iss_valid(iss_valid), .iss_dst_en(iss_dst_en), .iss_dst(iss_dst),
        .iss_tag(iss_tag), .iss_src(iss_src),
        .src_kind(src_kind), .src_tag(src_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .cm_valid(cm_valid), .cm_reg(cm_reg), .cm_tag(cm_tag)
    );

    task automatic clear_in();
        flush = 0; iss_valid = 0; iss_dst_en = 0; iss_dst = '0; iss_tag = '0;
        iss_src = '0; bc_valid = 0; bc_tag = '0; cm_valid = 0; cm_reg = '0; cm_tag = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    task automatic issue(input int dst, input int tg);
        iss_valid = 1; iss_dst_en = 1; iss_dst = REG_W'(dst); iss_tag = TAG_W'(tg);
    endtask

    task automatic bcast(input int tg);
        bc_valid = 1; bc_tag = TAG_W'(tg);
    endtask

    task automatic commit(input int r, input int tg);
        cm_valid = 1; cm_reg = REG_W'(r); cm_tag = TAG_W'(tg);
    endtask

    task automatic chk_src(input int port, input int kexp, input int texp, input string req);
        int ka, ta;
        #1;
        ka = int'(src_kind[port]);
        ta = int'(src_tag[port]);
        checks++;
        if (ka != kexp || ta != texp) begin
            failures++;
            $display("FAIL %s src%0d: kind=%0d tag=%0d expected kind=%0d tag=%0d",
                     req, port, ka, ta, kexp, texp);
        end
    endtask

    task automatic look(input int r, input int kexp, input int texp, input string req);
        iss_src[0] = REG_W'(r);
        chk_src(0, kexp, texp, req);
    endtask

    task automatic t_reset();
        iss_src[0] = 5'd3; iss_src[1] = 5'd7;
        chk_src(0, K_FILE, 0, "R1");
        chk_src(1, K_FILE, 0, "R1");
    endtask

    task automatic t_raw();
        issue(5, 9); tick();
        iss_src[1] = 5'd6;
        look(5, K_WAIT, 9, "R3");
        chk_src(1, K_FILE, 0, "R2");
    endtask

    task automatic t_bcast();
        bcast(9); tick();
        look(5, K_ROB, 9, "R4 R6");
        issue(8, 3); tick();
        bcast(4); tick();
        look(8, K_WAIT, 3, "R6 mismatched tag");
    endtask

    task automatic t_commit();
        commit(5, 9); tick();
        look(5, K_FILE, 0, "R7");
    endtask

    task automatic t_stale();
        issue(10, 1); tick();
        bcast(1); tick();
        issue(10, 2); tick();
        look(10, K_WAIT, 2, "R5 overwrite");
        tick();
        bcast(1); tick();
        look(10, K_WAIT, 2, "R6 stale broadcast");
        tick();
        bcast(2); tick();
        commit(10, 1); tick();
        look(10, K_ROB, 2, "R8 stale commit");
        tick();
        commit(10, 2); tick();
        look(10, K_FILE, 0, "R7 matching commit");
    endtask

    task automatic t_noupdate();
        iss_valid = 1; iss_dst_en = 0; iss_dst = 5'd11; iss_tag = 5'd5; tick();
        look(11, K_FILE, 0, "R5 dst disabled");
        tick();
        iss_valid = 0; iss_dst_en = 1; iss_dst = 5'd11; iss_tag = 5'd5; tick();
        look(11, K_FILE, 0, "R5 no issue");
    endtask

    task automatic t_bypass();
        issue(12, 6); tick();
        bcast(6);
        look(12, K_ROB, 6, "R9 same-cycle bypass");
        tick();
        look(12, K_ROB, 6, "R9 after edge");
    endtask

    task automatic t_self();
        issue(14, 7);
        look(14, K_FILE, 0, "R10 first self read");
        tick();
        issue(14, 11);
        iss_src[1] = 5'd14;
        chk_src(1, K_WAIT, 7, "R10 second self read");
        tick();
        look(14, K_WAIT, 11, "R5 new writer");
    endtask

    task automatic t_collide();
        issue(20, 3); tick();
        issue(20, 4); bcast(3); tick();
        look(20, K_WAIT, 4, "R12 issue over broadcast");
        tick();
        bcast(4); tick();
        issue(20, 5); commit(20, 4); tick();
        look(20, K_WAIT, 5, "R12 issue over commit");
    endtask

    task automatic t_flush();
        flush = 1; issue(21, 1); tick();
        look(8,  K_FILE, 0, "R11");
        look(12, K_FILE, 0, "R11");
        look(14, K_FILE, 0, "R11");
        look(20, K_FILE, 0, "R11");
        look(21, K_FILE, 0, "R11 flush over issue");
    endtask

    initial begin
        clear_in();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_raw();
        t_bcast();
        t_commit();
        t_stale();
        t_noupdate();
        t_bypass();
        t_self();
        t_collide();
        t_flush();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule